// File: doc/BRIEF.md
# HBM Command Profile Monitor

This block watches the write-command and read-command channels of one AXI4 port into a high-bandwidth-memory pseudo-channel controller. The controller accepts only a narrow subset of AXI: incrementing bursts, 32-byte beats, one or two beats per command, zero reserved user bits and a fixed protection code on reads. It also requires the low column-address bits to be aligned. Whenever a command is accepted, meaning valid and ready are both high in the same cycle, the monitor checks every field against that subset.

The monitor only observes and never changes, stalls or forwards traffic. When a command breaks one or more rules, one bit per broken rule is set in a sticky error vector. A registered one-cycle report also goes out, carrying the command ID, a read/write flag and the rules it broke. The `mode_pbl8` input selects the pseudo-BL8 profile, which is stricter about length and column alignment than the default BL4 profile. Asserting `clr_err` for one cycle empties the sticky vector.

Top module: `hbm_cmd_lint`

## Requirements
- R1: A command whose burst field is not 2'b01 (incrementing) sets rule bit 0.
- R2: A command whose size field is not 3'b101 (32-byte beat) sets rule bit 1.
- R3: The length field is checked against the mode and sets rule bit 2 when illegal. With `mode_pbl8`=0 the values 0 and 1 are legal. With `mode_pbl8`=1 only the value 1 is legal.
- R4: A nonzero value in user bits [13:1] sets rule bit 3. User bit 0, the auto-precharge request, is never flagged.
- R5: On the read channel, a protection field other than 3'b010 sets rule bit 4. The write-channel protection field is not checked.
- R6: Address bit 5, the lowest column bit with the default column position, must be 0. A set bit sets rule bit 5.
- R7: With `mode_pbl8`=1, address bit 6 (column bit 1) must be 0, and a set bit sets rule bit 6. With `mode_pbl8`=0 that bit is not checked.
- R8: The QoS field of either channel never causes a violation.
- R9: Fields are checked only in a handshake cycle. A command held with valid high and ready low never produces a report or a sticky bit.
- R10: One cycle after an accepted illegal command, `viol_pulse` is high for one cycle, together with the command's ID, `viol_is_rd` and the broken rules in `viol_rules`. If both channels are accepted with violations in the same cycle, only the write command is reported.
- R11: Sticky bits accumulate the violations of both channels and hold until `clr_err`. If a violation arrives in the same cycle as `clr_err`, its bits survive and all other bits are cleared.
- R12: After reset, `err_flags`, `viol_pulse` and `viol_rules` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pbl8 | input | 1 | 1 selects the pseudo-BL8 profile, 0 selects BL4 |
| clr_err | input | 1 | Clears the sticky error vector |
| wr_valid | input | 1 | Write-command valid (observed) |
| wr_ready | input | 1 | Write-command ready (observed) |
| wr_id | input | 7 | Write-command ID |
| wr_addr | input | 30 | Write-command address |
| wr_burst | input | 2 | Write burst type |
| wr_len | input | 8 | Write length (beats minus one) |
| wr_size | input | 3 | Write beat size code |
| wr_prot | input | 3 | Write protection field (not checked) |
| wr_qos | input | 4 | Write QoS (not checked) |
| wr_user | input | 14 | Write user field |
| rd_valid | input | 1 | Read-command valid (observed) |
| rd_ready | input | 1 | Read-command ready (observed) |
| rd_id | input | 7 | Read-command ID |
| rd_addr | input | 30 | Read-command address |
| rd_burst | input | 2 | Read burst type |
| rd_len | input | 8 | Read length (beats minus one) |
| rd_size | input | 3 | Read beat size code |
| rd_prot | input | 3 | Read protection field |
| rd_qos | input | 4 | Read QoS (not checked) |
| rd_user | input | 14 | Read user field |
| err_flags | output | 7 | Sticky per-rule error bits |
| viol_pulse | output | 1 | One-cycle violation report |
| viol_id | output | 7 | ID of the reported command |
| viol_is_rd | output | 1 | 1 when the reported command was a read |
| viol_rules | output | 7 | Rules broken by the reported command |

## Verification
The hardest case to reach is the same-cycle collision. In it, both channels complete a handshake with illegal fields in one cycle, or a new violation lands in the cycle that `clr_err` is high. The bench sets up both channels, or the clear and a channel, before a single rising edge and then releases them together. It then checks that the write command alone is reported, that the read's rule bit still reaches the sticky vector, and that only the fresh bit survives the clear. Stalled commands are held with bad fields and ready low for several cycles before the handshake is finally allowed.

// File: rtl/hbm_lint_pkg.sv
`timescale 1ns/1ps
package hbm_lint_pkg;
   localparam int NRULE    = 7;
   localparam int RB_BURST = 0;
   localparam int RB_SIZE  = 1;
   localparam int RB_LEN   = 2;
   localparam int RB_USER  = 3;
   localparam int RB_PROT  = 4;
   localparam int RB_COL0  = 5;
   localparam int RB_COL1  = 6;

   localparam logic [1:0] BURST_INCR = 2'b01;
   localparam logic [2:0] SIZE_32B   = 3'b101;
   localparam logic [2:0] PROT_READ  = 3'b010;

   typedef logic [NRULE-1:0] rule_vec_t;
endpackage

// File: rtl/hbm_cmd_rules.sv
`timescale 1ns/1ps
module hbm_cmd_rules
   import hbm_lint_pkg::*;
#(
   parameter int LEN_W   = 8,
   parameter int USER_W  = 14,
   parameter bit IS_READ = 1'b0
) (
   input  logic              mode_pbl8,
   input  logic [1:0]        col_lo,
   input  logic [1:0]        burst,
   input  logic [LEN_W-1:0]  len,
   input  logic [2:0]        size,
   input  logic [USER_W-1:0] user,
   input  logic [2:0]        prot,
   output rule_vec_t         bad
);
   logic len_ok;
   logic user_bad;
   logic prot_bad;

   always_comb begin
      if (mode_pbl8) len_ok = (len == LEN_W'(1));
      else           len_ok = (len <= LEN_W'(1));
   end

   generate
      if (USER_W > 1) begin : g_user
         logic unused_ap;
         assign unused_ap = user[0];
         assign user_bad  = |user[USER_W-1:1];
      end else begin : g_user_none
         logic unused_ap;
         assign unused_ap = user[0];
         assign user_bad  = 1'b0;
      end

      if (IS_READ) begin : g_prot_rd
         assign prot_bad = (prot != PROT_READ);
      end else begin : g_prot_wr
         logic unused_prot;
         assign unused_prot = ^prot;
         assign prot_bad    = 1'b0;
      end
   endgenerate

   always_comb begin
      bad           = '0;
      bad[RB_BURST] = (burst != BURST_INCR);
      bad[RB_SIZE]  = (size != SIZE_32B);
      bad[RB_LEN]   = !len_ok;
      bad[RB_USER]  = user_bad;
      bad[RB_PROT]  = prot_bad;
      bad[RB_COL0]  = col_lo[0];
      bad[RB_COL1]  = mode_pbl8 & col_lo[1];
   end
endmodule

// File: rtl/hbm_err_sticky.sv
`timescale 1ns/1ps
module hbm_err_sticky
   import hbm_lint_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  rule_vec_t set_vec,
   output rule_vec_t flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (clr ? '0 : flags) | set_vec;
   end
endmodule

// File: rtl/hbm_viol_report.sv
`timescale 1ns/1ps
module hbm_viol_report
   import hbm_lint_pkg::*;
#(
   parameter int ID_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_hs,
   input  rule_vec_t       wr_bad,
   input  logic [ID_W-1:0] wr_id,
   input  logic            rd_hs,
   input  rule_vec_t       rd_bad,
   input  logic [ID_W-1:0] rd_id,
   output logic            pulse,
   output logic [ID_W-1:0] id,
   output logic            is_rd,
   output rule_vec_t       rules
);
   logic wr_fire, rd_fire;
   assign wr_fire = wr_hs && (|wr_bad);
   assign rd_fire = rd_hs && (|rd_bad);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse <= 1'b0;
         id    <= '0;
         is_rd <= 1'b0;
         rules <= '0;
      end else begin
         pulse <= wr_fire | rd_fire;
         if (wr_fire) begin
            id    <= wr_id;
            is_rd <= 1'b0;
            rules <= wr_bad;
         end else if (rd_fire) begin
            id    <= rd_id;
            is_rd <= 1'b1;
            rules <= rd_bad;
         end else begin
            rules <= '0;
         end
      end
   end
endmodule

// File: rtl/hbm_cmd_lint.sv
`timescale 1ns/1ps
module hbm_cmd_lint
   import hbm_lint_pkg::*;
#(
   parameter int ADDR_W  = 30,
   parameter int ID_W    = 7,
   parameter int LEN_W   = 8,
   parameter int USER_W  = 14,
   parameter int COL_LSB = 5,
   parameter int COL_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_pbl8,
   input  logic              clr_err,
   input  logic              wr_valid,
   input  logic              wr_ready,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [1:0]        wr_burst,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [2:0]        wr_size,
   input  logic [2:0]        wr_prot,
   input  logic [3:0]        wr_qos,
   input  logic [USER_W-1:0] wr_user,
   input  logic              rd_valid,
   input  logic              rd_ready,
   input  logic [ID_W-1:0]   rd_id,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_burst,
   input  logic [LEN_W-1:0]  rd_len,
   input  logic [2:0]        rd_size,
   input  logic [2:0]        rd_prot,
   input  logic [3:0]        rd_qos,
   input  logic [USER_W-1:0] rd_user,
   output logic [NRULE-1:0]  err_flags,
   output logic              viol_pulse,
   output logic [ID_W-1:0]   viol_id,
   output logic              viol_is_rd,
   output logic [NRULE-1:0]  viol_rules
);
   localparam int COL_MSB = COL_LSB + COL_W - 1;

   generate
      if (COL_W < 2) begin : g_chk_colw
         $error("COL_W must cover at least two column bits");
      end
      if (COL_MSB >= ADDR_W) begin : g_chk_colpos
         $error("column field exceeds the address width");
      end
      if (LEN_W < 1 || ID_W < 1 || USER_W < 1) begin : g_chk_w
         $error("field widths must be positive");
      end
   endgenerate

   logic      wr_hs, rd_hs;
   rule_vec_t wr_bad, rd_bad, set_vec;

   assign wr_hs = wr_valid & wr_ready;
   assign rd_hs = rd_valid & rd_ready;

   logic unused_fields;
   assign unused_fields = ^{wr_qos, rd_qos, wr_addr, rd_addr};

   hbm_cmd_rules #(.LEN_W(LEN_W), .USER_W(USER_W), .IS_READ(1'b0)) u_wr_rules (
      .mode_pbl8 (mode_pbl8),
      .col_lo    (wr_addr[COL_LSB+1:COL_LSB]),
      .burst     (wr_burst),
      .len       (wr_len),
      .size      (wr_size),
      .user      (wr_user),
      .prot      (wr_prot),
      .bad       (wr_bad)
   );

   hbm_cmd_rules #(.LEN_W(LEN_W), .USER_W(USER_W), .IS_READ(1'b1)) u_rd_rules (
      .mode_pbl8 (mode_pbl8),
      .col_lo    (rd_addr[COL_LSB+1:COL_LSB]),
      .burst     (rd_burst),
      .len       (rd_len),
      .size      (rd_size),
      .user      (rd_user),
      .prot      (rd_prot),
      .bad       (rd_bad)
   );

   assign set_vec = (wr_hs ? wr_bad : '0) | (rd_hs ? rd_bad : '0);

   hbm_err_sticky u_sticky (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_err),
      .set_vec (set_vec),
      .flags   (err_flags)
   );

   hbm_viol_report #(.ID_W(ID_W)) u_report (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hs  (wr_hs),
      .wr_bad (wr_bad),
      .wr_id  (wr_id),
      .rd_hs  (rd_hs),
      .rd_bad (rd_bad),
      .rd_id  (rd_id),
      .pulse  (viol_pulse),
      .id     (viol_id),
      .is_rd  (viol_is_rd),
      .rules  (viol_rules)
   );
endmodule

// File: rtl/hbm_cmd_lint_chk.sv
`timescale 1ns/1ps
module hbm_cmd_lint_chk
   import hbm_lint_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             mode_pbl8,
   input logic             clr_err,
   input logic             wr_valid,
   input logic             wr_ready,
   input logic             rd_valid,
   input logic             rd_ready,
   input logic [NRULE-1:0] err_flags,
   input logic             viol_pulse,
   input logic             viol_is_rd,
   input logic [NRULE-1:0] viol_rules
);
   assert_hold_until_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_err |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

   assert_report_in_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> ((viol_rules & ~err_flags) == '0));

   assert_report_needs_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> $past((wr_valid && wr_ready) || (rd_valid && rd_ready)));

   assert_report_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> (viol_rules != '0));

   assert_no_write_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && !viol_is_rd) |-> !viol_rules[RB_PROT]);

   assert_col1_only_pbl8_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && viol_rules[RB_COL1]) |-> $past(mode_pbl8));
endmodule

bind hbm_cmd_lint hbm_cmd_lint_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_pbl8  (mode_pbl8),
   .clr_err    (clr_err),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .rd_valid   (rd_valid),
   .rd_ready   (rd_ready),
   .err_flags  (err_flags),
   .viol_pulse (viol_pulse),
   .viol_is_rd (viol_is_rd),
   .viol_rules (viol_rules)
);

// File: tb/hbm_cmd_lint_bench.sv
`timescale 1ns/1ps
module hbm_cmd_lint_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_pbl8 = 1'b0;
   logic        clr_err = 1'b0;
   logic        wr_valid = 1'b0, wr_ready = 1'b0;
   logic [6:0]  wr_id = '0;
   logic [29:0] wr_addr = '0;
   logic [1:0]  wr_burst = 2'b01;
   logic [7:0]  wr_len = '0;
   logic [2:0]  wr_size = 3'b101;
   logic [2:0]  wr_prot = '0;
   logic [3:0]  wr_qos = '0;
   logic [13:0] wr_user = '0;
   logic        rd_valid = 1'b0, rd_ready = 1'b0;
   logic [6:0]  rd_id = '0;
   logic [29:0] rd_addr = '0;
   logic [1:0]  rd_burst = 2'b01;
   logic [7:0]  rd_len = '0;
   logic [2:0]  rd_size = 3'b101;
   logic [2:0]  rd_prot = 3'b010;
   logic [3:0]  rd_qos = '0;
   logic [13:0] rd_user = '0;
   logic [6:0]  err_flags;
   logic        viol_pulse;
   logic [6:0]  viol_id;
   logic        viol_is_rd;
   logic [6:0]  viol_rules;

   int n_tests = 0;
   int n_fail  = 0;
   logic [6:0] exp_err = '0;

   always #10 clk = ~clk;

   hbm_cmd_lint u_hbm_cmd_lint (.*);

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   function automatic logic [6:0] exp_rules(input bit rd, input logic [29:0] addr, input logic [1:0] burst,
                                            input logic [7:0] len, input logic [2:0] size,
                                            input logic [13:0] user, input logic [2:0] prot);
      logic [6:0] e = '0;
      e[0] = (burst != 2'b01);
      e[1] = (size != 3'b101);
      e[2] = mode_pbl8 ? (len != 8'd1) : (len > 8'd1);
      e[3] = (user[13:1] != 13'd0);
      e[4] = rd && (prot != 3'b010);
      e[5] = addr[5];
      e[6] = mode_pbl8 && addr[6];
      return e;
   endfunction

   task automatic set_legal();
      wr_addr = '0; wr_burst = 2'b01; wr_len = 8'd1; wr_size = 3'b101; wr_prot = '0; wr_qos = '0; wr_user = '0;
      rd_addr = '0; rd_burst = 2'b01; rd_len = 8'd1; rd_size = 3'b101; rd_prot = 3'b010; rd_qos = '0; rd_user = '0;
   endtask

   // Drives one accepted command on one channel (fields already set) and checks the report.
   task automatic fire(input string req, input bit rd, input logic [6:0] id);
      logic [6:0] e;
      if (rd) begin
         rd_id = id; rd_valid = 1'b1; rd_ready = 1'b1;
         e = exp_rules(1'b1, rd_addr, rd_burst, rd_len, rd_size, rd_user, rd_prot);
      end else begin
         wr_id = id; wr_valid = 1'b1; wr_ready = 1'b1;
         e = exp_rules(1'b0, wr_addr, wr_burst, wr_len, wr_size, wr_user, wr_prot);
      end
      @(negedge clk);
      wr_valid = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0; rd_ready = 1'b0;
      exp_err |= e;
      chk(req, "viol_pulse", 32'(viol_pulse), 32'(e != 0));
      chk(req, "viol_rules", 32'(viol_rules), 32'(e));
      if (e != 0) begin
         chk(req, "viol_id", 32'(viol_id), 32'(id));
         chk(req, "viol_is_rd", 32'(viol_is_rd), 32'(rd));
      end
      chk(req, "err_flags", 32'(err_flags), 32'(exp_err));
   endtask

   task automatic do_clear();
      clr_err = 1'b1;
      @(negedge clk);
      clr_err = 1'b0;
      exp_err = '0;
      chk("R11", "err_flags after clear", 32'(err_flags), 32'h0);
   endtask

   task automatic t_reset();
      chk("R12", "err_flags", 32'(err_flags), 32'h0);
      chk("R12", "viol_pulse", 32'(viol_pulse), 32'h0);
      chk("R12", "viol_rules", 32'(viol_rules), 32'h0);
   endtask

   task automatic t_burst_size();
      set_legal(); wr_burst = 2'b00;      fire("R1", 1'b0, 7'h11);
      set_legal(); rd_burst = 2'b10;      fire("R1", 1'b1, 7'h12);
      set_legal(); rd_size = 3'b100;      fire("R2", 1'b1, 7'h13);
      set_legal(); wr_size = 3'b110;      fire("R2", 1'b0, 7'h14);
      do_clear();
   endtask

   task automatic t_length();
      mode_pbl8 = 1'b0;
      set_legal(); wr_len = 8'd0;         fire("R3", 1'b0, 7'h20);
      set_legal(); rd_len = 8'd1;         fire("R3", 1'b1, 7'h21);
      set_legal(); wr_len = 8'd2;         fire("R3", 1'b0, 7'h22);
      set_legal(); rd_len = 8'hFF;        fire("R3", 1'b1, 7'h23);
      mode_pbl8 = 1'b1;
      set_legal(); wr_len = 8'd0;         fire("R3", 1'b0, 7'h24);
      set_legal(); rd_len = 8'd1;         fire("R3", 1'b1, 7'h25);
      mode_pbl8 = 1'b0;
      do_clear();
   endtask

   task automatic t_user_prot();
      set_legal(); wr_user = 14'h0001;    fire("R4", 1'b0, 7'h30);
      set_legal(); rd_user = 14'h2000;    fire("R4", 1'b1, 7'h31);
      set_legal(); wr_user = 14'h0002;    fire("R4", 1'b0, 7'h32);
      set_legal(); wr_prot = 3'b111;      fire("R5", 1'b0, 7'h33);
      set_legal(); rd_prot = 3'b000;      fire("R5", 1'b1, 7'h34);
      do_clear();
   endtask

   task automatic t_column();
      mode_pbl8 = 1'b0;
      set_legal(); wr_addr = 30'h20;      fire("R6", 1'b0, 7'h40);
      set_legal(); rd_addr = 30'h40;      fire("R7", 1'b1, 7'h41);
      mode_pbl8 = 1'b1;
      set_legal(); rd_addr = 30'h40;      fire("R7", 1'b1, 7'h42);
      set_legal(); wr_addr = 30'h3FFF_FF9F; fire("R7", 1'b0, 7'h43);
      set_legal(); wr_addr = 30'h60; wr_len = 8'd0; wr_size = 3'b000; fire("R7", 1'b0, 7'h44);
      mode_pbl8 = 1'b0;
      do_clear();
   endtask

   task automatic t_qos();
      set_legal(); wr_qos = 4'hF;         fire("R8", 1'b0, 7'h50);
      set_legal(); rd_qos = 4'h8;         fire("R8", 1'b1, 7'h51);
   endtask

   task automatic t_stall();
      set_legal(); wr_burst = 2'b11; wr_id = 7'h60;
      wr_valid = 1'b1; wr_ready = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R9", "stall viol_pulse", 32'(viol_pulse), 32'h0);
         chk("R9", "stall err_flags", 32'(err_flags), 32'(exp_err));
      end
      wr_valid = 1'b0; wr_ready = 1'b1;
      @(negedge clk);
      chk("R9", "ready-only viol_pulse", 32'(viol_pulse), 32'h0);
      wr_ready = 1'b0;
      fire("R9", 1'b0, 7'h60);
      do_clear();
   endtask

   task automatic t_both();
      set_legal();
      wr_burst = 2'b00; wr_id = 7'h05;
      rd_size = 3'b011; rd_id = 7'h09;
      wr_valid = 1'b1; wr_ready = 1'b1; rd_valid = 1'b1; rd_ready = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; wr_ready = 1'b0; rd_valid = 1'b0; rd_ready = 1'b0;
      chk("R10", "both viol_pulse", 32'(viol_pulse), 32'h1);
      chk("R10", "both viol_id", 32'(viol_id), 32'h05);
      chk("R10", "both viol_is_rd", 32'(viol_is_rd), 32'h0);
      chk("R10", "both viol_rules", 32'(viol_rules), 32'h01);
      chk("R11", "both err_flags", 32'(err_flags), 32'h03);
      @(negedge clk);
      chk("R10", "pulse one cycle", 32'(viol_pulse), 32'h0);
      exp_err = 7'h03;
      do_clear();
   endtask

   task automatic t_sticky();
      set_legal(); wr_burst = 2'b10;      fire("R11", 1'b0, 7'h70);
      repeat (5) @(negedge clk);
      chk("R11", "held err_flags", 32'(err_flags), 32'h01);
      set_legal(); rd_size = 3'b001;
      rd_id = 7'h71; rd_valid = 1'b1; rd_ready = 1'b1; clr_err = 1'b1;
      @(negedge clk);
      rd_valid = 1'b0; rd_ready = 1'b0; clr_err = 1'b0;
      chk("R11", "clear+set err_flags", 32'(err_flags), 32'h02);
      chk("R10", "clear+set viol_id", 32'(viol_id), 32'h71);
      exp_err = 7'h02;
      do_clear();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_burst_size();
      t_length();
      t_user_prot();
      t_column();
      t_qos();
      t_stall();
      t_both();
      t_sticky();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule